// File: doc/BRIEF.md
# Real-Time Clock Update Interrupt Unit

This unit turns the carry pulses of a real-time clock's timekeeping chain into a periodic interrupt. Software picks whether the interrupt follows the seconds carry or the minutes carry. Each such event sets a sticky status bit. When the source is enabled, each event also asserts an active-low open-drain interrupt line. The line is modelled as a pull-low enable, `irq_pull`, where 1 means the pin is driven low. The pull releases itself on the first 128 Hz tick after the event, whatever the status bit holds. Software can also cancel it at once by clearing the enable bit.

Three byte-wide registers hold the controls, and all of this unit's bits sit in bit 5:
- the mode register (default 0xD) holds the minute/second choice;
- the status register (0xE) holds the sticky update bit;
- the control register (0xF) holds the interrupt enable in bit 5 and a chain-halt bit in bit 0.

While the chain-halt bit is set, no update events occur. The final pull-low also includes a request from the other interrupt sources of the clock. That request enters on `ext_req`.

Top module: `rtc_upd_irq`

## Requirements
- R1: After a synchronous reset, `irq_pull` is 0 and every register reads 0x00.
- R2: With the mode bit (0xD bit 5) at 0, a `sec_pulse` sets the status bit (0xE bit 5), and a `min_pulse` alone leaves it unchanged.
- R3: With the mode bit at 1, a `min_pulse` sets the status bit, and a `sec_pulse` alone leaves it unchanged.
- R4: The status bit holds at 1 until a write to 0xE with bit 5 at 0. A write with bit 5 at 1 leaves it unchanged. A clearing write in the same cycle as an event leaves it at 1.
- R5: With the enable (0xF bit 5) at 1, an event sets `irq_pull` to 1 in the cycle after the event's clock edge.
- R6: With the enable at 0, an event still sets the status bit but does not raise `irq_pull`.
- R7: An event-driven `irq_pull` returns to 0 after the first `tick_128` that follows the event, and the status bit stays 1.
- R8: Clearing the status bit does not release an asserted `irq_pull`.
- R9: A write to 0xF with bit 5 at 0 releases this unit's request in the next cycle. This holds even if an event arrives in the same cycle.
- R10: While the chain-halt bit (0xF bit 0) is 1, neither pulse sets the status bit or raises `irq_pull`.
- R11: `ext_req` at 1 makes `irq_pull` 1 in the next cycle, whatever the enable holds.
- R12: `rdata` is registered. It shows the register at the `addr` of the previous edge. 0xD and 0xE show only bit 5, 0xF shows only bits 5 and 0, and all other addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_pulse | input | 1 | One-cycle pulse on each seconds carry |
| min_pulse | input | 1 | One-cycle pulse on each minutes carry |
| tick_128 | input | 1 | One-cycle pulse at 128 Hz |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ext_req | input | 1 | Pull-low request from other interrupt sources |
| irq_pull | output | 1 | 1 drives the open-drain interrupt pin low |

## Verification
Seconds and minutes pulses are applied under both mode settings. This shows whether the event source is actually qualified by the mode bit or whether both carries leak through. Status-register writes of 0, of 1 and of 0 coinciding with an event separate a true write-zero-to-clear bit from a plain writable or toggling one. Event, tick, status-clear and enable-clear sequences separate the self-releasing pull from one tied to the status bit. An external request with the enable at 0, and pulses with the halt bit set, show the OR path and the event gating.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  // Default register map of the update-interrupt unit
  localparam int unsigned MODE_ADDR = 4'hD;
  localparam int unsigned STAT_ADDR = 4'hE;
  localparam int unsigned CTRL_ADDR = 4'hF;
  localparam int unsigned FIELD_BIT = 5;
  localparam int unsigned HALT_BIT  = 0;

  typedef struct packed {
    logic minute_mode;
    logic upd_flag;
    logic irq_en;
    logic halt;
  } upd_regs_t;
endpackage

// File: rtl/rtc_upd_event.sv
module rtc_upd_event (
  input  logic minute_mode,
  input  logic halt,
  input  logic sec_pulse,
  input  logic min_pulse,
  output logic evt
);
  logic src;
  always_comb begin
    src = minute_mode ? min_pulse : sec_pulse;
    evt = src & ~halt;
  end
endmodule

// File: rtl/rtc_upd_regs.sv
module rtc_upd_regs
  import rtc_upd_pkg::*;
#(
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned MODE_A = MODE_ADDR,
  parameter int unsigned STAT_A = STAT_ADDR,
  parameter int unsigned CTRL_A = CTRL_ADDR,
  parameter int unsigned FBIT   = FIELD_BIT,
  parameter int unsigned HBIT   = HALT_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          evt,
  output upd_regs_t     regs,
  output logic          en_drop,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] A_MODE = AW'(MODE_A);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_A);
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_A);

  logic          wr_mode, wr_stat, wr_ctrl;
  logic [DW-1:0] rd_next;

  always_comb begin
    wr_mode = wr_en && (addr == A_MODE);
    wr_stat = wr_en && (addr == A_STAT);
    wr_ctrl = wr_en && (addr == A_CTRL);
    en_drop = wr_ctrl && !wdata[FBIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      if (wr_mode) regs.minute_mode <= wdata[FBIT];
      if (wr_ctrl) begin
        regs.irq_en <= wdata[FBIT];
        regs.halt   <= wdata[HBIT];
      end
      // event has priority over a clearing write; writing 1 does nothing
      if (evt)                          regs.upd_flag <= 1'b1;
      else if (wr_stat && !wdata[FBIT]) regs.upd_flag <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < int'(DW); i++) begin
      if (i == int'(FBIT)) begin
        unique case (addr)
          A_MODE:  rd_next[i] = regs.minute_mode;
          A_STAT:  rd_next[i] = regs.upd_flag;
          A_CTRL:  rd_next[i] = regs.irq_en;
          default: rd_next[i] = 1'b0;
        endcase
      end else if (i == int'(HBIT)) begin
        rd_next[i] = (addr == A_CTRL) && regs.halt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/rtc_upd_req.sv
module rtc_upd_req (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic irq_en,
  input  logic en_drop,
  input  logic tick_128,
  input  logic ext_req,
  output logic src_req,
  output logic irq_pull
);
  logic req_next;

  always_comb begin
    if (en_drop)              req_next = 1'b0;
    else if (evt && irq_en)   req_next = 1'b1;
    else if (tick_128)        req_next = 1'b0;
    else                      req_next = src_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_req  <= 1'b0;
      irq_pull <= 1'b0;
    end else begin
      src_req  <= req_next;
      irq_pull <= req_next | ext_req;
    end
  end
endmodule

// File: rtl/rtc_upd_irq.sv
module rtc_upd_irq
  import rtc_upd_pkg::*;
#(
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned MODE_A = MODE_ADDR,
  parameter int unsigned STAT_A = STAT_ADDR,
  parameter int unsigned CTRL_A = CTRL_ADDR,
  parameter int unsigned FBIT   = FIELD_BIT,
  parameter int unsigned HBIT   = HALT_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sec_pulse,
  input  logic          min_pulse,
  input  logic          tick_128,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ext_req,
  output logic          irq_pull
);
  upd_regs_t regs;
  logic      evt, en_drop, src_req;

  rtc_upd_event u_event (
    .minute_mode (regs.minute_mode),
    .halt        (regs.halt),
    .sec_pulse   (sec_pulse),
    .min_pulse   (min_pulse),
    .evt         (evt)
  );

  rtc_upd_regs #(
    .AW(AW), .DW(DW), .MODE_A(MODE_A), .STAT_A(STAT_A),
    .CTRL_A(CTRL_A), .FBIT(FBIT), .HBIT(HBIT)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .evt     (evt),
    .regs    (regs),
    .en_drop (en_drop),
    .rdata   (rdata)
  );

  rtc_upd_req u_req (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .irq_en   (regs.irq_en),
    .en_drop  (en_drop),
    .tick_128 (tick_128),
    .ext_req  (ext_req),
    .src_req  (src_req),
    .irq_pull (irq_pull)
  );
endmodule

// File: rtl/rtc_upd_chk.sv
module rtc_upd_chk #(
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned STAT_A = 14,
  parameter int unsigned CTRL_A = 15,
  parameter int unsigned FBIT   = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          sec_pulse,
  input logic          min_pulse,
  input logic          tick_128,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          ext_req,
  input logic          irq_pull,
  input logic          flag,
  input logic          irq_en,
  input logic          halt,
  input logic          src_req
);
  logic stat_clr, ctrl_wr;
  always_comb begin
    stat_clr = wr_en && (addr == AW'(STAT_A)) && !wdata[FBIT];
    ctrl_wr  = wr_en && (addr == AW'(CTRL_A));
  end

  // R4: flag only drops through a clearing write
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (flag && !stat_clr) |=> flag);

  // R10: halted chain produces no new flag
  p_halt_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (halt && !ctrl_wr && !flag) |=> !flag);

  // R6: disabled source never requests
  p_no_req_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !ctrl_wr) |=> !src_req);

  // R7: request released after a tick with no new event
  p_auto_release_r7: assert property (@(posedge clk) disable iff (rst)
    (tick_128 && !sec_pulse && !min_pulse) |=> !src_req);

  // R9: clearing the enable cancels the request
  p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wdata[FBIT]) |=> !src_req);

  // R11: external request always reaches the pin
  p_ext_or_r11: assert property (@(posedge clk) disable iff (rst)
    ext_req |=> irq_pull);
endmodule

bind rtc_upd_irq rtc_upd_chk #(
  .AW(AW), .DW(DW), .STAT_A(STAT_A), .CTRL_A(CTRL_A), .FBIT(FBIT)
) i_chk (
  .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .min_pulse(min_pulse),
  .tick_128(tick_128), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ext_req(ext_req), .irq_pull(irq_pull), .flag(regs.upd_flag),
  .irq_en(regs.irq_en), .halt(regs.halt), .src_req(src_req)
);

// File: tb/test_rtc_upd_irq.sv
module test_rtc_upd_irq;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_pulse = 0, min_pulse = 0, tick_128 = 0, wr_en = 0, ext_req = 0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_pull;

  int errors = 0;
  int checks = 0;

  rtc_upd_irq i_rtc_upd_irq (
    .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .min_pulse(min_pulse),
    .tick_128(tick_128), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_req(ext_req), .irq_pull(irq_pull)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  bit m_mode, m_flag, m_en, m_halt, m_req, m_valid;
  bit [7:0] m_rdata;
  bit m_irq;
  always @(posedge clk) begin
    bit ev, drop;
    if (rst) begin
      m_mode = 0; m_flag = 0; m_en = 0; m_halt = 0; m_req = 0;
      m_rdata = 0; m_irq = 0; m_valid = 1;
    end else begin
      case (addr)
        4'hD:    m_rdata = m_mode ? 8'h20 : 8'h00;
        4'hE:    m_rdata = m_flag ? 8'h20 : 8'h00;
        4'hF:    m_rdata = (m_en ? 8'h20 : 8'h00) | (m_halt ? 8'h01 : 8'h00);
        default: m_rdata = 8'h00;
      endcase
      ev   = !m_halt && (m_mode ? min_pulse : sec_pulse);
      drop = wr_en && addr == 4'hF && !wdata[5];
      if (drop)             m_req = 0;
      else if (ev && m_en)  m_req = 1;
      else if (tick_128)    m_req = 0;
      if (ev)                                         m_flag = 1;
      else if (wr_en && addr == 4'hE && !wdata[5])    m_flag = 0;
      if (wr_en && addr == 4'hD) m_mode = wdata[5];
      if (wr_en && addr == 4'hF) begin m_en = wdata[5]; m_halt = wdata[0]; end
      m_irq = m_req | ext_req;
    end
  end

  always @(negedge clk) begin
    if (m_valid) begin
      checks++;
      if (rdata !== m_rdata || irq_pull !== m_irq) begin
        errors++;
        $display("FAIL model R5/R12 cycle: rdata=%h irq=%b expected rdata=%h irq=%b",
                 rdata, irq_pull, m_rdata, m_irq);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at a falling edge, cleared after
  task automatic step(input bit s, input bit m, input bit t, input bit w,
                      input logic [3:0] a, input logic [7:0] d);
    sec_pulse = s; min_pulse = m; tick_128 = t; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    sec_pulse = 0; min_pulse = 0; tick_128 = 0; wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(0, 0, 0, 1, a, d);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    check("R1 irq", {7'd0, irq_pull}, 8'h00);
    rd(4'hD, v); check("R1 mode", v, 8'h00);
    rd(4'hE, v); check("R1 stat", v, 8'h00);
    rd(4'hF, v); check("R1 ctrl", v, 8'h00);
    // R2 second mode
    step(1, 0, 0, 0, 4'hE, 0); rd(4'hE, v); check("R2 sec sets", v, 8'h20);
    wr(4'hE, 8'h00);
    step(0, 1, 0, 0, 4'hE, 0); rd(4'hE, v); check("R2 min ignored", v, 8'h00);
    // R3 minute mode
    wr(4'hD, 8'hFF); rd(4'hD, v); check("R3 mode reads", v, 8'h20);
    step(1, 0, 0, 0, 4'hE, 0); rd(4'hE, v); check("R3 sec ignored", v, 8'h00);
    step(0, 1, 0, 0, 4'hE, 0); rd(4'hE, v); check("R3 min sets", v, 8'h20);
    // R4 write one, collision
    wr(4'hE, 8'hFF); rd(4'hE, v); check("R4 write one", v, 8'h20);
    wr(4'hE, 8'h00); rd(4'hE, v); check("R4 write zero", v, 8'h00);
    step(0, 1, 0, 1, 4'hE, 8'h00); rd(4'hE, v); check("R4 event wins", v, 8'h20);
    wr(4'hE, 8'h00);
    // R5, R8, R7
    wr(4'hF, 8'h20);
    step(0, 1, 0, 0, 4'hF, 0); check("R5 irq set", {7'd0, irq_pull}, 8'h01);
    wr(4'hE, 8'h00); check("R8 clear flag keeps irq", {7'd0, irq_pull}, 8'h01);
    step(0, 0, 0, 0, 4'hE, 0); check("R7 hold until tick", {7'd0, irq_pull}, 8'h01);
    step(0, 1, 0, 0, 4'hE, 0);
    step(0, 0, 1, 0, 4'hE, 0); check("R7 released on tick", {7'd0, irq_pull}, 8'h00);
    rd(4'hE, v); check("R7 flag stays", v, 8'h20);
    // R9 cancel, also with simultaneous event
    step(0, 1, 0, 0, 4'hE, 0); check("R9 pre", {7'd0, irq_pull}, 8'h01);
    wr(4'hF, 8'h00); check("R9 cancel", {7'd0, irq_pull}, 8'h00);
    wr(4'hF, 8'h20);
    step(0, 1, 0, 1, 4'hF, 8'h00); check("R9 cancel beats event", {7'd0, irq_pull}, 8'h00);
    // R6 disabled
    wr(4'hE, 8'h00);
    step(0, 1, 0, 0, 4'hE, 0); check("R6 no irq", {7'd0, irq_pull}, 8'h00);
    rd(4'hE, v); check("R6 flag sets", v, 8'h20);
    // R10 halt
    wr(4'hF, 8'h21); wr(4'hE, 8'h00);
    step(1, 1, 0, 0, 4'hE, 0); check("R10 no irq", {7'd0, irq_pull}, 8'h00);
    rd(4'hE, v); check("R10 no flag", v, 8'h00);
    rd(4'hF, v); check("R12 ctrl bits", v, 8'h21);
    rd(4'h3, v); check("R12 unmapped", v, 8'h00);
    // R11 external
    wr(4'hF, 8'h00);
    ext_req = 1; @(negedge clk); check("R11 ext", {7'd0, irq_pull}, 8'h01);
    ext_req = 0; @(negedge clk); check("R11 ext off", {7'd0, irq_pull}, 8'h00);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule